// File: doc/BRIEF.md
# Clock Output Divider and Peripheral Clock Gate

This block sits in a chip's clock-control area. It takes the high-speed system clock and produces three gated clocks: an external clock output carrying the high-speed clock divided by 1, 2 or 4, an external output that passes the low-speed oscillator clock through, and the peripheral clock that feeds the internal peripherals. Software controls all three through two 8-bit registers on a simple write-strobe and combinational-read port.

The divide ratio is managed by a two-state machine. In state RATIO_IDLE the applied ratio matches the stored code, or the stored code is the reserved value 3. A write of a different valid code moves the machine to RATIO_PENDING (transition IDLE→PENDING on change request). The machine returns to RATIO_IDLE and applies the waiting ratio when the 2-bit divide counter wraps from 3 to 0 (transition PENDING→IDLE on wrap). At that edge every ratio's waveform goes from low to high together, so the switch cannot leave a runt pulse. Each of the three clocks passes through a gate whose enable is captured by a latch that is open only while the source clock is low.

The peripheral clock is supplied only when its 2-bit enable field holds 3 and the external run input is 1. Field values 1 and 2 are prohibited settings. They are stored and read back, but they keep the clock off.

Top module: `clkout_ctrl`

## Requirements
- R1: After reset the output register (address 0x5081) reads 0x00, the peripheral register (address 0x5080) reads 0x03, the applied ratio is divide-by-1, and with the run input at 0 all three clock outputs stay low.
- R2: Output register bits [3:2] select the ratio of `fout_div` to `hs_clk`: code 0 gives 1/1, code 1 gives 1/2, code 2 gives 1/4.
- R3: Writing divide code 3 stores it and reads it back unchanged, while the previously applied ratio stays in force.
- R4: Output register bit 1 set to 1 lets the divided clock out on `fout_div`. At 0 that output stays low.
- R5: Output register bit 0 set to 1 passes `ls_clk` to `fout_ls`. At 0 that output stays low.
- R6: The peripheral register keeps its enable field in bits [1:0], and its bits [7:2] read 0. Output register bits [7:4] read 0. Any other address reads 0x00.
- R7: `pclk_out` follows `hs_clk` only while the enable field is 3 and `periph_run` is 1. It is low when the field is 0 or when the run input is 0.
- R8: Enable field codes 1 and 2 are stored and read back, but `pclk_out` stays low while either code is held.
- R9: A gate's enable takes effect only while its source clock is low. `pclk_out` is therefore low whenever `hs_clk` is low, and no gated output shows a pulse shorter than half an `hs_clk` period.
- R10: A new divide ratio is applied only at the edge where the divide counter wraps from 3 to 0, so no runt pulse appears on `fout_div`.
- R11: A register changes only on an `hs_clk` edge where `wr_en` is 1. `rdata` follows `addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hs_clk | input | 1 | High-speed clock: register clock and divider source |
| rst_n | input | 1 | Asynchronous active-low reset |
| ls_clk | input | 1 | Low-speed oscillator clock to pass through |
| periph_run | input | 1 | External run bit for the peripheral clock |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W (16) | Register address |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, combinational from addr |
| fout_div | output | 1 | Gated, divided high-speed clock |
| fout_ls | output | 1 | Gated low-speed clock |
| pclk_out | output | 1 | Gated peripheral clock |

## Verification
Each output clock is measured by counting its rising edges over a fixed 16-cycle window. The counts 16, 8, 4 and 0 separate divide-by-1, divide-by-2, divide-by-4 and gated off. The divide codes are written in turn, then code 3 is written both with the output enable set and with it cleared. This shows that the reserved code keeps the last ratio. The peripheral enable field takes all four codes with the run input at 1 and at 0, which separates the one enabling combination from the stored but prohibited codes. Ratio changes are also written at every phase of the divide counter while a monitor tracks the narrowest high and low pulse. A switch that ignores the counter wrap would show up as a pulse narrower than half a clock period.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    // Divide-select codes for the external high-speed output
    typedef enum logic [1:0] {
        DIV_1    = 2'd0,
        DIV_2    = 2'd1,
        DIV_4    = 2'd2,
        DIV_RSVD = 2'd3
    } div_sel_e;

    // Ratio-switch state machine
    typedef enum logic {
        RATIO_IDLE    = 1'b0,
        RATIO_PENDING = 1'b1
    } ratio_state_e;

    // Peripheral clock enable field codes
    localparam logic [1:0] PCK_ON  = 2'b11;
    localparam logic [1:0] PCK_OFF = 2'b00;

    // Field positions in the output register
    localparam int LS_EN_BIT  = 0;
    localparam int DIV_EN_BIT = 1;
    localparam int DIV_LSB    = 2;

endpackage

// File: rtl/clkout_regs.sv
module clkout_regs
    import clkout_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] PCLK_ADDR = 16'h5080,
    parameter logic [15:0] FOUT_ADDR = 16'h5081
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ls_en,
    output logic              div_en,
    output div_sel_e          div_code,
    output logic [1:0]        pcken
);

    localparam logic [ADDR_W-1:0] A_PCLK = PCLK_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] A_FOUT = FOUT_ADDR[ADDR_W-1:0];

    logic hit_pclk;
    logic hit_fout;
    logic unused_wbits;

    assign hit_pclk     = (addr == A_PCLK);
    assign hit_fout     = (addr == A_FOUT);
    assign unused_wbits = ^wdata[DATA_W-1:DIV_LSB+2];

    // Register storage, written only on the strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ls_en    <= 1'b0;
            div_en   <= 1'b0;
            div_code <= DIV_1;
            pcken    <= PCK_ON;
        end else if (wr_en) begin
            if (hit_fout) begin
                ls_en    <= wdata[LS_EN_BIT];
                div_en   <= wdata[DIV_EN_BIT];
                div_code <= div_sel_e'(wdata[DIV_LSB +: 2]);
            end
            if (hit_pclk) begin
                pcken <= wdata[1:0];
            end
        end
    end

    // Combinational read path
    always_comb begin
        rdata = '0;
        if (hit_pclk) begin
            rdata[1:0] = pcken;
        end else if (hit_fout) begin
            rdata[LS_EN_BIT]      = ls_en;
            rdata[DIV_EN_BIT]     = div_en;
            rdata[DIV_LSB +: 2]   = div_code;
        end
    end

endmodule

// File: rtl/clkout_divider.sv
module clkout_divider
    import clkout_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  div_sel_e         code,
    output logic             div_clk,
    output logic [CNT_W-1:0] cnt,
    output div_sel_e         ratio,
    output ratio_state_e     state
);

    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    ratio_state_e state_d;
    div_sel_e     target_q;
    logic         wrap;
    logic         change_req;

    assign wrap       = (cnt == CNT_LAST);
    assign change_req = (code != DIV_RSVD) && (code != ratio);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RATIO_IDLE;
        end else begin
            state <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            RATIO_IDLE: begin
                if (change_req) state_d = RATIO_PENDING;
            end
            RATIO_PENDING: begin
                if (wrap) state_d = RATIO_IDLE;
            end
        endcase
    end

    // Outputs: counter, waiting target and applied ratio
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            target_q <= DIV_1;
            ratio    <= DIV_1;
        end else begin
            cnt <= cnt + 1'b1;
            if (code != DIV_RSVD) begin
                target_q <= code;
            end
            unique case (state)
                RATIO_IDLE:    ;
                RATIO_PENDING: if (wrap) ratio <= target_q;
            endcase
        end
    end

    // Ratio select: all three waveforms rise together at the wrap edge
    always_comb begin
        unique case (ratio)
            DIV_1:   div_clk = clk;
            DIV_2:   div_clk = ~cnt[0];
            DIV_4:   div_clk = ~cnt[CNT_W-1];
            default: div_clk = clk;
        endcase
    end

endmodule

// File: rtl/clkout_gate.sv
module clkout_gate (
    input  logic clk_i,
    input  logic en_i,
    output logic clk_o
);

    logic en_lat;

    // Enable is captured only while the source clock is low
    always_latch begin
        if (!clk_i) begin
            en_lat = en_i;
        end
    end

    assign clk_o = clk_i & en_lat;

endmodule

// File: rtl/clkout_ctrl.sv
module clkout_ctrl
    import clkout_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          CNT_W     = 2,
    parameter logic [15:0] PCLK_ADDR = 16'h5080,
    parameter logic [15:0] FOUT_ADDR = 16'h5081
) (
    input  logic              hs_clk,
    input  logic              rst_n,
    input  logic              ls_clk,
    input  logic              periph_run,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              fout_div,
    output logic              fout_ls,
    output logic              pclk_out
);

    localparam int N_GATES = 3;

    logic             ls_en;
    logic             div_en;
    div_sel_e         div_code;
    logic [1:0]       pcken;
    logic             div_clk;
    logic [CNT_W-1:0] div_cnt;
    div_sel_e         ratio;
    ratio_state_e     ratio_state;
    logic             pclk_req;

    logic [N_GATES-1:0] gate_src;
    logic [N_GATES-1:0] gate_en;
    logic [N_GATES-1:0] gate_out;

    clkout_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PCLK_ADDR (PCLK_ADDR),
        .FOUT_ADDR (FOUT_ADDR)
    ) u_regs (
        .clk      (hs_clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .ls_en    (ls_en),
        .div_en   (div_en),
        .div_code (div_code),
        .pcken    (pcken)
    );

    clkout_divider #(
        .CNT_W (CNT_W)
    ) u_div (
        .clk     (hs_clk),
        .rst_n   (rst_n),
        .code    (div_code),
        .div_clk (div_clk),
        .cnt     (div_cnt),
        .ratio   (ratio),
        .state   (ratio_state)
    );

    // Only the fully-on code together with the run input supplies the clock
    assign pclk_req = (pcken == PCK_ON) && periph_run;

    assign gate_src = {hs_clk,   ls_clk, div_clk};
    assign gate_en  = {pclk_req, ls_en,  div_en};

    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        clkout_gate u_gate (
            .clk_i (gate_src[g]),
            .en_i  (gate_en[g]),
            .clk_o (gate_out[g])
        );
    end

    assign fout_div = gate_out[0];
    assign fout_ls  = gate_out[1];
    assign pclk_out = gate_out[2];

endmodule

// File: rtl/clkout_ctrl_chk.sv
module clkout_ctrl_chk
    import clkout_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter int          CNT_W     = 2,
    parameter logic [15:0] PCLK_ADDR = 16'h5080
) (
    input logic              hs_clk,
    input logic              rst_n,
    input logic              periph_run,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic              pclk_out,
    input logic              ls_en,
    input logic              div_en,
    input div_sel_e          div_code,
    input logic [1:0]        pcken,
    input logic [CNT_W-1:0]  div_cnt,
    input div_sel_e          ratio,
    input ratio_state_e      ratio_state
);

    localparam logic [ADDR_W-1:0] A_PCLK = PCLK_ADDR[ADDR_W-1:0];

    AST_RSVD_BITS_ZERO: assert property (@(posedge hs_clk) disable iff (!rst_n)
        (addr == A_PCLK) |-> (rdata[DATA_W-1:2] == '0)); // R6

    AST_RSVD_CODE_HOLDS: assert property (@(posedge hs_clk) disable iff (!rst_n)
        (div_code == DIV_RSVD && ratio_state == RATIO_IDLE)
        |=> (ratio_state == RATIO_IDLE) && $stable(ratio)); // R3

    AST_RATIO_AT_WRAP: assert property (@(posedge hs_clk) disable iff (!rst_n)
        (ratio != $past(ratio)) |-> (div_cnt == '0)); // R10

    AST_PCLK_LOW_PHASE: assert property (@(posedge hs_clk) disable iff (!rst_n)
        !pclk_out); // R9

    AST_PCLK_BAD_CODE: assert property (@(negedge hs_clk) disable iff (!rst_n)
        (pcken != PCK_ON && $past(pcken) != PCK_ON) |-> !pclk_out); // R8

    AST_PCLK_RUNS: assert property (@(negedge hs_clk) disable iff (!rst_n)
        ($past(pcken) == PCK_ON && periph_run && $past(periph_run)) |-> pclk_out); // R7

    AST_WRITE_STROBE: assert property (@(posedge hs_clk) disable iff (!rst_n)
        !wr_en |=> $stable(pcken) && $stable(div_code) && $stable(ls_en) && $stable(div_en)); // R11

endmodule

bind clkout_ctrl clkout_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .PCLK_ADDR (PCLK_ADDR)
) u_chk (
    .hs_clk      (hs_clk),
    .rst_n       (rst_n),
    .periph_run  (periph_run),
    .wr_en       (wr_en),
    .addr        (addr),
    .rdata       (rdata),
    .pclk_out    (pclk_out),
    .ls_en       (ls_en),
    .div_en      (div_en),
    .div_code    (div_code),
    .pcken       (pcken),
    .div_cnt     (div_cnt),
    .ratio       (ratio),
    .ratio_state (ratio_state)
);

// File: tb/clkout_ctrl_test.sv
module clkout_ctrl_test;

    localparam logic [15:0] A_PCLK = 16'h5080;
    localparam logic [15:0] A_FOUT = 16'h5081;

    typedef struct packed {
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic        run;
        logic [7:0]  n_div;
        logic [7:0]  n_ls;
        logic [7:0]  n_pclk;
        logic [7:0]  rd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{A_FOUT, 8'h03, 1'b0, 8'd16, 8'd4, 8'd0,  8'h03}, // R2 R4 R5: div1
        '{A_FOUT, 8'h07, 1'b0, 8'd8,  8'd4, 8'd0,  8'h07}, // R2 div2
        '{A_FOUT, 8'h0B, 1'b0, 8'd4,  8'd4, 8'd0,  8'h0B}, // R2 div4
        '{A_FOUT, 8'h0F, 1'b0, 8'd4,  8'd4, 8'd0,  8'h0F}, // R3 reserved keeps div4
        '{A_FOUT, 8'h0E, 1'b0, 8'd4,  8'd0, 8'd0,  8'h0E}, // R3 R5 ls off
        '{A_PCLK, 8'h03, 1'b1, 8'd4,  8'd0, 8'd16, 8'h03}, // R7 on
        '{A_PCLK, 8'hFF, 1'b1, 8'd4,  8'd0, 8'd16, 8'h03}, // R6 reserved bits
        '{A_PCLK, 8'h01, 1'b1, 8'd4,  8'd0, 8'd0,  8'h01}, // R8
        '{A_PCLK, 8'h02, 1'b1, 8'd4,  8'd0, 8'd0,  8'h02}, // R8
        '{A_PCLK, 8'h00, 1'b1, 8'd4,  8'd0, 8'd0,  8'h00}, // R7 field off
        '{A_PCLK, 8'h03, 1'b0, 8'd4,  8'd0, 8'd0,  8'h03}, // R7 run off
        '{A_FOUT, 8'h02, 1'b1, 8'd16, 8'd0, 8'd16, 8'h02}, // R2 back to div1
        '{A_FOUT, 8'hF1, 1'b1, 8'd0,  8'd4, 8'd16, 8'h01}  // R4 R6 div off
    };

    logic        hs_clk = 1'b0;
    logic        ls_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        periph_run = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        fout_div;
    logic        fout_ls;
    logic        pclk_out;

    int total = 0;
    int bad = 0;
    int n_div = 0;
    int n_ls = 0;
    int n_pclk = 0;
    bit mon_on = 1'b0;
    real t_rise = 0.0;
    real t_fall = 0.0;
    real min_hi = 1.0e9;
    real min_lo = 1.0e9;

    clkout_ctrl uut (
        .hs_clk     (hs_clk),
        .rst_n      (rst_n),
        .ls_clk     (ls_clk),
        .periph_run (periph_run),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .fout_div   (fout_div),
        .fout_ls    (fout_ls),
        .pclk_out   (pclk_out)
    );

    // 125 MHz: 8 time units per period
    always #4 hs_clk = ~hs_clk;
    initial begin
        #1;
        forever #16 ls_clk = ~ls_clk;
    end

    always @(posedge fout_div) n_div++;
    always @(posedge fout_ls)  n_ls++;
    always @(posedge pclk_out) n_pclk++;

    // Pulse-width monitor for runt detection
    always @(posedge fout_div) begin
        if (mon_on && ($realtime - t_fall) < min_lo) min_lo = $realtime - t_fall;
        t_rise = $realtime;
    end
    always @(negedge fout_div) begin
        if (mon_on && ($realtime - t_rise) < min_hi) min_hi = $realtime - t_rise;
        t_fall = $realtime;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge hs_clk);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge hs_clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge hs_clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic measure(output int nd, output int nl, output int np);
        @(negedge hs_clk);
        n_div  = 0;
        n_ls   = 0;
        n_pclk = 0;
        repeat (16) @(negedge hs_clk);
        nd = n_div;
        nl = n_ls;
        np = n_pclk;
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        int nd, nl, np;

        repeat (3) @(negedge hs_clk);
        rst_n = 1'b1;
        repeat (2) @(negedge hs_clk);

        // Reset state (R1)
        reg_read(A_PCLK, rd);
        check("R1 pclk reg reset", rd, 8'h03);
        reg_read(A_FOUT, rd);
        check("R1 fout reg reset", rd, 8'h00);
        measure(nd, nl, np);
        check("R1 fout_div silent", nd, 0);
        check("R1 fout_ls silent", nl, 0);
        check("R1 pclk silent", np, 0);

        // Unmapped address (R6)
        reg_read(16'h5082, rd);
        check("R6 unmapped read", rd, 8'h00);

        mon_on = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge hs_clk);
            periph_run = VEC[i].run;
            reg_write(VEC[i].addr, VEC[i].wdata);
            repeat (8) @(negedge hs_clk);
            measure(nd, nl, np);
            check($sformatf("R2/R3/R4 vec%0d div edges", i), nd, int'(VEC[i].n_div));
            check($sformatf("R5 vec%0d ls edges", i), nl, int'(VEC[i].n_ls));
            check($sformatf("R7/R8 vec%0d pclk edges", i), np, int'(VEC[i].n_pclk));
            reg_read(VEC[i].addr, rd);
            check($sformatf("R6 vec%0d readback", i), rd, int'(VEC[i].rd));
        end

        // Strobe low: address and data held, nothing stored (R11)
        @(negedge hs_clk);
        addr  = A_FOUT;
        wdata = 8'h0B;
        repeat (4) @(negedge hs_clk);
        #1;
        check("R11 no write without strobe", rdata, 8'h01);
        addr = A_PCLK;
        #1;
        check("R11 combinational read", rdata, 8'h03);

        // Ratio switches at every counter phase (R10, R9)
        for (int ph = 0; ph < 4; ph++) begin
            reg_write(A_FOUT, 8'h0A);
            repeat (ph + 5) @(negedge hs_clk);
            reg_write(A_FOUT, 8'h02);
            repeat (ph + 3) @(negedge hs_clk);
            periph_run = ~periph_run;
            reg_write(A_FOUT, 8'h06);
            repeat (ph + 6) @(negedge hs_clk);
            reg_write(A_FOUT, 8'h00);
            repeat (ph + 2) @(negedge hs_clk);
        end
        reg_write(A_FOUT, 8'h0A);
        repeat (8) @(negedge hs_clk);
        measure(nd, nl, np);
        check("R10 div4 after switches", nd, 4);
        check("R9 R10 min high width x10", int'(min_hi * 10.0) >= 40 ? 1 : 0, 1);
        check("R9 R10 min low width x10", int'(min_lo * 10.0) >= 40 ? 1 : 0, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule